// File: doc/BRIEF.md
# Complementary PWM Output Stage with Dead Time

This block turns one reference PWM level into a complementary pair of outputs, a main leg and a negated leg, each with its own output-enable. Every leg has a channel enable and a polarity bit. A global output enable and a run-mode off-state select decide what an unused leg does. When both legs are enabled, the block delays each leg's transition to its active level by a programmable number of timer clocks. This keeps the two legs from being active at the same moment and leaves a gap between them.

The counter and compare logic that produce the reference are outside the block. So are the idle-state handling and the break inputs. When the global enable is low, both legs are simply driven low and disabled. All outputs are registered, so every result shows up one clock after the inputs that cause it are sampled.

Top module: `comp_pwm_stage`

## Requirements
- R1: While the global enable `out_en` is 0, all four outputs (`main_o`, `main_oe`, `comp_o`, `comp_oe`) are 0 one cycle later.
- R2: With `out_en`=1, `run_off_sel`=0 and both channel enables 0, both legs are low and disabled.
- R3: With `out_en`=1, `run_off_sel`=0, `main_en`=1 and `comp_en`=0, `main_o` = `ref_i` XOR `main_pol` with `main_oe`=1, and the complementary leg is low with `comp_oe`=0.
- R4: With `out_en`=1, `run_off_sel`=0, `main_en`=0 and `comp_en`=1, the main leg is low with `main_oe`=0, and `comp_o` = `ref_i` XOR `comp_pol` (the reference is not inverted) with `comp_oe`=1.
- R5: With `out_en`=1, `run_off_sel`=1 and both channel enables 0, `main_o`=`main_pol` and `comp_o`=`comp_pol`, and both output-enables are 0.
- R6: With `out_en`=1, `run_off_sel`=1 and exactly one channel enable set, the enabled leg is the reference XOR its polarity, and the other leg is driven to its own polarity bit (its inactive level). Both output-enables are 1.
- R7: With `out_en`=1 and both channel enables set, both output-enables are 1. `main_o` = shaped(`ref_i`) XOR `main_pol` and `comp_o` = shaped(NOT `ref_i`) XOR `comp_pol`. `run_off_sel` has no effect in this mode.
- R8: Dead time. On every change of `ref_i`, an internal down-counter loads `dt_count`. When `ref_i` rises, the shaped complementary level drops in the very cycle of the edge, and the shaped main level rises `dt_count` cycles later. A fall works the same way with the legs swapped.
- R9: A `dt_count` of 0 adds no delay. If `dt_count` is equal to or greater than the number of cycles the reference holds a level, the delayed leg never goes active for that interval.
- R10: Whenever both output-enables are 1, the two legs are never at their active levels together. The active level of a leg is the inverse of its polarity bit.
- R11: All outputs are registered with one cycle of latency. Synchronous reset clears them to 0 and treats the reference as having been low for a long time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference PWM level |
| out_en | input | 1 | Global output enable |
| run_off_sel | input | 1 | Run-mode off-state select |
| main_en | input | 1 | Main leg channel enable |
| comp_en | input | 1 | Complementary leg channel enable |
| main_pol | input | 1 | Main leg polarity (1 = active low) |
| comp_pol | input | 1 | Complementary leg polarity (1 = active low) |
| dt_count | input | DT_W | Dead-time length in clocks |
| main_o | output | 1 | Main leg level |
| main_oe | output | 1 | Main leg output-enable |
| comp_o | output | 1 | Complementary leg level |
| comp_oe | output | 1 | Complementary leg output-enable |

## Verification
Every output reflects the inputs that were sampled at the previous rising edge. The bench changes inputs on the falling edge and compares the outputs at the next falling edge against values worked out from those same inputs.

A rising reference edge takes the shaped main level up `dt_count` cycles after the edge's own result. The bench's model follows this by counting how long the current reference level has lasted and recording the count value at the edge. A leg may go active only once that run length exceeds the recorded count. Directed runs place pulses one cycle shorter than, equal to and longer than the dead time, so those boundaries land on exact cycles.

// File: rtl/comp_pwm_pkg.sv
package comp_pwm_pkg;

  // What a leg drives before registering
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,  // constant low
    SRC_POL    = 2'd1,  // its own polarity bit (inactive level)
    SRC_REF    = 2'd2,  // raw reference XOR polarity
    SRC_SHAPED = 2'd3   // dead-time shaped level XOR polarity
  } leg_src_e;

  typedef struct packed {
    leg_src_e src;
    logic     oe;
  } leg_ctl_t;

  localparam int unsigned LEG_MAIN = 0;
  localparam int unsigned LEG_COMP = 1;
  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/comp_pwm_dt_gen.sv
module comp_pwm_dt_gen #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_count,
  output logic            shaped_main,
  output logic            shaped_comp
);

  localparam logic [DT_W-1:0] CNT_ZERO = '0;
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  logic            ref_q;
  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_d;
  logic            edge_seen;
  logic            gate_open;

  assign edge_seen = (ref_i != ref_q);

  always_comb begin
    if (edge_seen)
      cnt_d = dt_count;
    else if (cnt_q != CNT_ZERO)
      cnt_d = cnt_q - CNT_ONE;
    else
      cnt_d = CNT_ZERO;
  end

  assign gate_open   = (cnt_d == CNT_ZERO);
  assign shaped_main = ref_i  & gate_open;
  assign shaped_comp = ~ref_i & gate_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else begin
      ref_q <= ref_i;
      cnt_q <= cnt_d;
    end
  end

  // R8: each reference edge reloads the dead-time counter
  a_r8_load_on_edge: assert property (@(posedge clk) disable iff (rst)
    (ref_i != ref_q) |=> (cnt_q == $past(dt_count)));

  // R9: with no edge and an empty counter, the counter stays empty
  a_r9_idle_counter: assert property (@(posedge clk) disable iff (rst)
    (ref_i == ref_q && cnt_q == CNT_ZERO) |=> (cnt_q == CNT_ZERO || ref_q != $past(ref_q)));

endmodule

// File: rtl/comp_pwm_mode_table.sv
module comp_pwm_mode_table
  import comp_pwm_pkg::*;
(
  input  logic     out_en,
  input  logic     run_off_sel,
  input  logic     main_en,
  input  logic     comp_en,
  output leg_ctl_t main_ctl,
  output leg_ctl_t comp_ctl
);

  leg_ctl_t unused_ctl;

  always_comb begin
    // a leg that is switched off: inactive level kept driven only in run off-state mode
    unused_ctl.src = run_off_sel ? SRC_POL : SRC_ZERO;
    unused_ctl.oe  = run_off_sel;

    main_ctl = '{src: SRC_ZERO, oe: 1'b0};
    comp_ctl = '{src: SRC_ZERO, oe: 1'b0};

    if (out_en) begin
      unique case ({main_en, comp_en})
        2'b11: begin
          main_ctl = '{src: SRC_SHAPED, oe: 1'b1};
          comp_ctl = '{src: SRC_SHAPED, oe: 1'b1};
        end
        2'b10: begin
          main_ctl = '{src: SRC_REF, oe: 1'b1};
          comp_ctl = unused_ctl;
        end
        2'b01: begin
          main_ctl = unused_ctl;
          comp_ctl = '{src: SRC_REF, oe: 1'b1};
        end
        default: begin
          main_ctl = '{src: unused_ctl.src, oe: 1'b0};
          comp_ctl = '{src: unused_ctl.src, oe: 1'b0};
        end
      endcase
    end
  end

endmodule

// File: rtl/comp_pwm_leg.sv
module comp_pwm_leg
  import comp_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  leg_ctl_t ctl,
  input  logic     pol,
  input  logic     raw_lvl,
  input  logic     shaped_lvl,
  output logic     lvl_o,
  output logic     oe_o
);

  logic lvl_d;

  always_comb begin
    unique case (ctl.src)
      SRC_ZERO:   lvl_d = 1'b0;
      SRC_POL:    lvl_d = pol;
      SRC_REF:    lvl_d = raw_lvl ^ pol;
      SRC_SHAPED: lvl_d = shaped_lvl ^ pol;
      default:    lvl_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      lvl_o <= lvl_d;
      oe_o  <= ctl.oe;
    end
  end

  // R2: a disabled leg that is told to sit at zero shows zero on the next cycle
  a_r2_zero_src: assert property (@(posedge clk) disable iff (rst)
    (ctl.src == SRC_ZERO) |=> (lvl_o == 1'b0));

endmodule

// File: rtl/comp_pwm_stage.sv
module comp_pwm_stage
  import comp_pwm_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_i,
  input  logic            out_en,
  input  logic            run_off_sel,
  input  logic            main_en,
  input  logic            comp_en,
  input  logic            main_pol,
  input  logic            comp_pol,
  input  logic [DT_W-1:0] dt_count,
  output logic            main_o,
  output logic            main_oe,
  output logic            comp_o,
  output logic            comp_oe
);

  logic     shaped_main;
  logic     shaped_comp;
  leg_ctl_t main_ctl;
  leg_ctl_t comp_ctl;

  leg_ctl_t             leg_ctl [NUM_LEGS];
  logic [NUM_LEGS-1:0]  leg_pol;
  logic [NUM_LEGS-1:0]  leg_raw;
  logic [NUM_LEGS-1:0]  leg_shaped;
  logic [NUM_LEGS-1:0]  leg_lvl;
  logic [NUM_LEGS-1:0]  leg_oe;

  comp_pwm_dt_gen #(.DT_W(DT_W)) u_dt_gen (
    .clk         (clk),
    .rst         (rst),
    .ref_i       (ref_i),
    .dt_count    (dt_count),
    .shaped_main (shaped_main),
    .shaped_comp (shaped_comp)
  );

  comp_pwm_mode_table u_mode_table (
    .out_en      (out_en),
    .run_off_sel (run_off_sel),
    .main_en     (main_en),
    .comp_en     (comp_en),
    .main_ctl    (main_ctl),
    .comp_ctl    (comp_ctl)
  );

  assign leg_ctl[LEG_MAIN]    = main_ctl;
  assign leg_ctl[LEG_COMP]    = comp_ctl;
  assign leg_pol[LEG_MAIN]    = main_pol;
  assign leg_pol[LEG_COMP]    = comp_pol;
  // both legs take the reference uninverted in single-leg modes
  assign leg_raw[LEG_MAIN]    = ref_i;
  assign leg_raw[LEG_COMP]    = ref_i;
  assign leg_shaped[LEG_MAIN] = shaped_main;
  assign leg_shaped[LEG_COMP] = shaped_comp;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    comp_pwm_leg u_leg (
      .clk        (clk),
      .rst        (rst),
      .ctl        (leg_ctl[g]),
      .pol        (leg_pol[g]),
      .raw_lvl    (leg_raw[g]),
      .shaped_lvl (leg_shaped[g]),
      .lvl_o      (leg_lvl[g]),
      .oe_o       (leg_oe[g])
    );
  end

  assign main_o  = leg_lvl[LEG_MAIN];
  assign main_oe = leg_oe[LEG_MAIN];
  assign comp_o  = leg_lvl[LEG_COMP];
  assign comp_oe = leg_oe[LEG_COMP];

  // R1: global enable low forces everything low and disabled
  a_r1_global_off: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!main_o && !main_oe && !comp_o && !comp_oe));

  // R10: never both legs active while both drive
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (main_oe && comp_oe) |-> !((main_o != main_pol) && (comp_o != comp_pol)
                               && $stable(main_pol) && $stable(comp_pol)));

  // R5: off-state select with no channel enabled parks each leg at its polarity
  a_r5_park_pol: assert property (@(posedge clk) disable iff (rst)
    (out_en && run_off_sel && !main_en && !comp_en)
      |=> (main_o == $past(main_pol) && comp_o == $past(comp_pol) && !main_oe && !comp_oe));

  // R8: with both legs on, a low reference turns the main leg inactive at once
  a_r8_fall_at_once: assert property (@(posedge clk) disable iff (rst)
    (out_en && main_en && comp_en && !ref_i) |=> (main_o == $past(main_pol) && main_oe));

endmodule

// File: tb/test_comp_pwm_stage.sv
`timescale 1ns/1ps
module test_comp_pwm_stage;

  localparam int unsigned DT_W = 8;

  logic clk = 1'b0;
  logic rst;
  logic ref_i, out_en, run_off_sel, main_en, comp_en, main_pol, comp_pol;
  logic [DT_W-1:0] dt_count;
  logic main_o, main_oe, comp_o, comp_oe;

  always #5 clk = ~clk;

  comp_pwm_stage #(.DT_W(DT_W)) i_comp_pwm_stage (
    .clk(clk), .rst(rst), .ref_i(ref_i), .out_en(out_en),
    .run_off_sel(run_off_sel), .main_en(main_en), .comp_en(comp_en),
    .main_pol(main_pol), .comp_pol(comp_pol), .dt_count(dt_count),
    .main_o(main_o), .main_oe(main_oe), .comp_o(comp_o), .comp_oe(comp_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string force_tag = "";

  // bench model of the dead-time shaping: run length of the current level
  logic m_prev;
  int   m_run;
  int   m_dt;

  task automatic model_reset();
    m_prev = 1'b0;
    m_run  = 100000;
    m_dt   = 0;
  endtask

  function automatic logic [3:0] f_expect(input logic dmain, input logic dcomp);
    logic [3:0] e;
    if (!out_en) e = 4'b0000;
    else if (main_en && comp_en) e = {dmain ^ main_pol, 1'b1, dcomp ^ comp_pol, 1'b1};
    else if (main_en) e = run_off_sel ? {ref_i ^ main_pol, 1'b1, comp_pol, 1'b1}
                                      : {ref_i ^ main_pol, 1'b1, 1'b0, 1'b0};
    else if (comp_en) e = run_off_sel ? {main_pol, 1'b1, ref_i ^ comp_pol, 1'b1}
                                      : {1'b0, 1'b0, ref_i ^ comp_pol, 1'b1};
    else e = run_off_sel ? {main_pol, 1'b0, comp_pol, 1'b0} : 4'b0000;
    return e;
  endfunction

  function automatic string f_tag();
    if (force_tag != "") return force_tag;
    if (!out_en) return "R1";
    if (main_en && comp_en) return "R7";
    if (run_off_sel && (main_en || comp_en)) return "R6";
    if (run_off_sel) return "R5";
    if (main_en) return "R3";
    if (comp_en) return "R4";
    return "R2";
  endfunction

  // inputs already driven; advance one clock and check the registered result
  task automatic tick();
    logic gate, dmain, dcomp;
    logic [3:0] exp_v, act_v;
    logic mp, cp;
    string tag;
    if (ref_i != m_prev) begin m_run = 1; m_dt = int'(dt_count); end
    else if (m_run < 100000) m_run++;
    m_prev = ref_i;
    gate  = (m_run > m_dt);
    dmain = ref_i & gate;
    dcomp = ~ref_i & gate;
    exp_v = f_expect(dmain, dcomp);
    tag   = f_tag();
    mp = main_pol; cp = comp_pol;
    @(negedge clk);
    act_v = {main_o, main_oe, comp_o, comp_oe};
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: outputs {o,oe,on,oen} actual %b expected %b", tag, act_v, exp_v);
    end
    n_tests++;
    if (main_oe && comp_oe && (main_o != mp) && (comp_o != cp)) begin
      n_fail++;
      $display("FAIL R10: both legs active, actual %b%b expected not both", main_o, comp_o);
    end
  endtask

  task automatic set_mode(input logic g, input logic r, input logic m, input logic c,
                          input logic mp, input logic cp);
    out_en = g; run_off_sel = r; main_en = m; comp_en = c; main_pol = mp; comp_pol = cp;
  endtask

  task automatic hold_ref(input logic lvl, input int cycles);
    ref_i = lvl;
    for (int i = 0; i < cycles; i++) tick();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ref_i = 1'b1; dt_count = 8'd5;
    set_mode(1, 1, 1, 1, 1, 1);
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    n_tests++;
    if ({main_o, main_oe, comp_o, comp_oe} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R11: reset outputs actual %b expected 0000",
               {main_o, main_oe, comp_o, comp_oe});
    end
    rst = 1'b0;
    ref_i = 1'b0;
    model_reset();

    // R11: first cycle after reset, low reference treated as long-settled
    force_tag = "R11";
    set_mode(1, 0, 1, 1, 0, 0);
    dt_count = 8'd4;
    tick();
    force_tag = "";

    // R1..R6: every row of the enable table, both polarities, both reference levels
    for (int k = 0; k < 64; k++) begin
      set_mode(k[0], k[1], k[2], k[3], k[4], k[5]);
      hold_ref(1'b0, 1);
      hold_ref(1'b1, 1);
    end

    // R8: dead time of 3 on both edges, active-high legs
    set_mode(1, 0, 1, 1, 0, 0);
    dt_count = 8'd3;
    force_tag = "R8";
    hold_ref(1'b0, 8);
    hold_ref(1'b1, 8);
    hold_ref(1'b0, 8);
    // R8 with active-low polarity: gaps inverted
    set_mode(1, 1, 1, 1, 1, 1);
    hold_ref(1'b1, 7);
    hold_ref(1'b0, 7);
    // R9: zero dead time
    dt_count = 8'd0;
    force_tag = "R9";
    set_mode(1, 0, 1, 1, 0, 1);
    hold_ref(1'b1, 3);
    hold_ref(1'b0, 1);
    hold_ref(1'b1, 1);
    hold_ref(1'b0, 3);
    // R9: pulse equal to, shorter than, one longer than the dead time
    dt_count = 8'd4;
    hold_ref(1'b1, 4);
    hold_ref(1'b0, 6);
    hold_ref(1'b1, 3);
    hold_ref(1'b0, 4);
    hold_ref(1'b1, 5);
    hold_ref(1'b0, 6);
    // R7: off-state select toggled while both legs run
    force_tag = "R7";
    set_mode(1, 1, 1, 1, 0, 0);
    hold_ref(1'b1, 6);
    run_off_sel = 1'b0;
    hold_ref(1'b0, 6);
    force_tag = "";

    // random segments, fixed seed
    begin
      int seed_val;
      seed_val = $urandom(32'h5eed_c0de);
    end
    for (int s = 0; s < 300; s++) begin
      logic [5:0] mode;
      mode = 6'($urandom);
      if ($urandom % 2 == 0) mode[3:2] = 2'b11;
      mode[0] = ($urandom % 8 != 0);
      set_mode(mode[0], mode[1], mode[2], mode[3], mode[4], mode[5]);
      dt_count = DT_W'($urandom % 11);
      for (int p = 0; p < 4; p++)
        hold_ref(~ref_i, 1 + int'($urandom % 12));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule